// File: doc/BRIEF.md
# Multi-Cause Fault Capture Latch

This block turns several raw protection detector lines (overcurrent, overvoltage, undervoltage, overtemperature) into a qualified, latched fault record. Each line passes through its own persistence filter, so a detector must stay active for a programmable number of clock cycles before it counts. Once accepted, the cause is held in a sticky bit until an explicit re-arm, so a brief qualified event cannot vanish before software gets to read it. The earliest accepted cause is also kept in a separate one-hot field.

All latched causes drive one shared active-low fault output, which can be wired to a common fault line. A single-cycle event pulse marks the change from "no fault" to "fault". Software clears the record by holding the re-arm input for a programmable minimum time. The clear only happens if every raw detector line is inactive at that moment. A startup blanking window, opened by a pulse and closed by its own counter, can keep selected causes out during inrush. A master enable stops new captures without losing what is already latched.

Top module: `fault_capture_latch`

## Requirements
- R1: A cause is accepted in the clock cycle of the Nth consecutive rising clock edge at which its raw input is sampled high, where N = `deglitch_cycles` (a value of 0 acts as 1). A shorter run is never accepted, and a single low sample restarts the count from zero.
- R2: Accepted cause bits are sticky. They OR-accumulate and stay set after the raw input falls, until a successful re-arm.
- R3: Cause bit positions in `cause_raw`, `cause_sticky`, `first_cause` and `blank_mask`: bit 0 overcurrent, bit 1 overvoltage, bit 2 undervoltage, bit 3 overtemperature.
- R4: `first_cause` is one-hot and holds the cause accepted while no cause was latched. If several are accepted in that same cycle, the lowest index wins (default priority). Later causes do not change it, and a re-arm clears it to zero.
- R5: `fault_n` is low exactly when any sticky cause bit is set, in the same cycle as the bits.
- R6: `fault_event` is high for exactly one cycle, the first cycle in which `cause_sticky` is non-zero after being zero. Causes added while already latched produce no pulse.
- R7: When `rearm_in` is sampled high for `rearm_cycles` consecutive edges (0 acts as 1) and all `cause_raw` bits are low at that last edge, `cause_sticky` and `first_cause` clear. A shorter hold has no effect.
- R8: If any `cause_raw` bit is high at the edge where the re-arm hold completes, nothing is cleared. Another attempt requires `rearm_in` to go low and be held again.
- R9: A `blank_start` pulse accepted while no window is open blanks the causes selected in `blank_mask` for the following `blank_cycles` edges: their filters are held at zero. Unselected causes are unaffected.
- R10: The blanking window closes by itself. A `blank_start` that arrives while a window is open is ignored and does not extend it.
- R11: While `arm_en` is low, no cause is accepted and all filters restart from zero. Already latched bits are kept.
- R12: After reset, `cause_sticky` and `first_cause` are zero, `fault_n` is high and `fault_event` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_en | input | 1 | Capture enable |
| cause_raw | input | NUM_CAUSES | Raw detector lines, active high |
| deglitch_cycles | input | DG_W | Required persistence for a cause |
| rearm_in | input | 1 | Re-arm request, active high |
| rearm_cycles | input | REARM_W | Required re-arm hold time |
| blank_start | input | 1 | Opens a blanking window |
| blank_cycles | input | BLANK_W | Blanking window length |
| blank_mask | input | NUM_CAUSES | Causes covered by blanking |
| cause_sticky | output | NUM_CAUSES | Latched cause tags |
| first_cause | output | NUM_CAUSES | One-hot earliest cause |
| fault_n | output | 1 | Aggregated fault, active low |
| fault_event | output | 1 | One-cycle pulse on first capture |

## Verification
The bench targets the corner cases that hide in off-by-one counting:
- A run one sample short of the persistence limit. A filter that counted one too few would accept it.
- A run broken by one low sample. A counter that did not restart would accept it.
- A re-arm that completes while a detector is still high, and the same hold continued after the detector drops. A design without the safe-clear gate, or one that retried during the same hold, would wipe the record.
- A second blanking pulse inside an open window. A retriggerable window would hide a later cause that must be caught.

Simultaneous first causes check the priority rule, and a zero threshold checks the acts-as-one rule. Long random traffic is then compared cycle by cycle against a reference model built from the requirements.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
   // Fixed tag positions of the standard detector set
   typedef enum int unsigned {
      CAUSE_OCP = 0,
      CAUSE_OVP = 1,
      CAUSE_UV  = 2,
      CAUSE_OT  = 3
   } cause_e;

   localparam int unsigned STD_CAUSES = 4;
   localparam int unsigned MAX_CAUSES = 32;
endpackage

// File: rtl/fcl_persist.sv
// Persistence timer: hit pulses once when go has been high for thr edges.
module fcl_persist #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] thr,
   output logic         hit
);
   logic [W-1:0] cnt;
   logic [W-1:0] thr_eff;

   assign thr_eff = (thr == '0) ? W'(1) : thr;
   assign hit     = go && (cnt == thr_eff - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!go) begin
         cnt <= '0;
      end else if (cnt < thr_eff) begin
         cnt <= cnt + W'(1);
      end
   end
endmodule

// File: rtl/fcl_blank.sv
// Non-retriggerable blanking window counter.
module fcl_blank #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] len,
   output logic         active
);
   logic [W-1:0] cnt;

   assign active = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start && !active) begin
         cnt <= len;
      end else if (active) begin
         cnt <= cnt - W'(1);
      end
   end
endmodule

// File: rtl/fcl_capture.sv
// Sticky cause record, first-cause pick and event pulse.
module fcl_capture #(
   parameter int unsigned N        = 4,
   parameter bit          PRIO_LSB = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] qual,
   input  logic         clear,
   output logic [N-1:0] sticky,
   output logic [N-1:0] first,
   output logic         event_o
);
   logic [N-1:0] pick;
   logic         empty;
   logic         opening;

   generate
      if (PRIO_LSB) begin : g_lsb
         assign pick = qual & (~qual + N'(1));
      end else begin : g_msb
         always_comb begin
            pick = '0;
            for (int k = 0; k < int'(N); k++) begin
               if (qual[k]) pick = N'(1) << k;
            end
         end
      end
   endgenerate

   assign empty   = (sticky == '0);
   assign opening = empty && (qual != '0) && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky  <= '0;
         first   <= '0;
         event_o <= 1'b0;
      end else begin
         event_o <= opening;
         if (clear) begin
            sticky <= '0;
            first  <= '0;
         end else begin
            sticky <= sticky | qual;
            if (opening) first <= pick;
         end
      end
   end
endmodule

// File: rtl/fault_capture_latch.sv
module fault_capture_latch #(
   parameter int unsigned NUM_CAUSES = fcl_pkg::STD_CAUSES,
   parameter int unsigned DG_W       = 8,
   parameter int unsigned REARM_W    = 8,
   parameter int unsigned BLANK_W    = 12,
   parameter bit          PRIO_LSB   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arm_en,
   input  logic [NUM_CAUSES-1:0] cause_raw,
   input  logic [DG_W-1:0]       deglitch_cycles,
   input  logic                  rearm_in,
   input  logic [REARM_W-1:0]    rearm_cycles,
   input  logic                  blank_start,
   input  logic [BLANK_W-1:0]    blank_cycles,
   input  logic [NUM_CAUSES-1:0] blank_mask,
   output logic [NUM_CAUSES-1:0] cause_sticky,
   output logic [NUM_CAUSES-1:0] first_cause,
   output logic                  fault_n,
   output logic                  fault_event
);
   localparam int unsigned N = NUM_CAUSES;

   generate
      if (N < 1 || N > fcl_pkg::MAX_CAUSES) begin : g_bad_n
         $error("NUM_CAUSES out of range");
      end
      if (DG_W < 1 || REARM_W < 1 || BLANK_W < 1) begin : g_bad_w
         $error("timer widths must be at least one bit");
      end
   endgenerate

   logic         blank_on;
   logic [N-1:0] dg_go;
   logic [N-1:0] qual;
   logic         rearm_hit;
   logic         clear;

   fcl_blank #(.W(BLANK_W)) u_blank (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (blank_start),
      .len    (blank_cycles),
      .active (blank_on)
   );

   generate
      for (genvar i = 0; i < int'(N); i++) begin : g_cause
         assign dg_go[i] = cause_raw[i] && arm_en && !(blank_on && blank_mask[i]);
         fcl_persist #(.W(DG_W)) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (dg_go[i]),
            .thr   (deglitch_cycles),
            .hit   (qual[i])
         );
      end
   endgenerate

   fcl_persist #(.W(REARM_W)) u_rearm (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (rearm_in),
      .thr   (rearm_cycles),
      .hit   (rearm_hit)
   );

   assign clear = rearm_hit && (cause_raw == '0);

   fcl_capture #(.N(N), .PRIO_LSB(PRIO_LSB)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .qual    (qual),
      .clear   (clear),
      .sticky  (cause_sticky),
      .first   (first_cause),
      .event_o (fault_event)
   );

   assign fault_n = ~|cause_sticky;
endmodule

// File: rtl/fcl_chk.sv
module fcl_chk #(
   parameter int unsigned N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] cause_raw,
   input logic         rearm_in,
   input logic [N-1:0] cause_sticky,
   input logic [N-1:0] first_cause,
   input logic         fault_n,
   input logic         fault_event
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R1
   set_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((cause_sticky & ~$past(cause_sticky) & ~$past(cause_raw)) == '0));

   // R2
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && (($past(cause_sticky) & ~cause_sticky) != '0))
      |-> ($past(rearm_in) && ($past(cause_raw) == '0)));

   // R4
   first_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_sticky != '0) |-> (($countones(first_cause) == 1) && ((first_cause & ~cause_sticky) == '0)));

   // R4
   first_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ($past(cause_sticky) != '0) && (cause_sticky != '0)) |-> $stable(first_cause));

   // R6
   event_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && fault_event) |-> (($past(cause_sticky) == '0) && (cause_sticky != '0)));

   // R5
   fault_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $fell(fault_n)) |-> fault_event);
endmodule

bind fault_capture_latch fcl_chk #(.N(NUM_CAUSES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cause_raw    (cause_raw),
   .rearm_in     (rearm_in),
   .cause_sticky (cause_sticky),
   .first_cause  (first_cause),
   .fault_n      (fault_n),
   .fault_event  (fault_event)
);

// File: tb/sim_fault_capture_latch.sv
`timescale 1ns/1ps
module sim_fault_capture_latch;
   localparam int NC = 4;
   localparam int WDOG_CYC = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_en = 1'b1;
   logic [NC-1:0] cause_raw = '0;
   logic [7:0]    deglitch_cycles = 8'd3;
   logic          rearm_in = 1'b0;
   logic [7:0]    rearm_cycles = 8'd4;
   logic          blank_start = 1'b0;
   logic [11:0]   blank_cycles = 12'd0;
   logic [NC-1:0] blank_mask = '0;
   logic [NC-1:0] cause_sticky, first_cause;
   logic          fault_n, fault_event;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fault_capture_latch u0 (
      .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .cause_raw(cause_raw),
      .deglitch_cycles(deglitch_cycles), .rearm_in(rearm_in),
      .rearm_cycles(rearm_cycles), .blank_start(blank_start),
      .blank_cycles(blank_cycles), .blank_mask(blank_mask),
      .cause_sticky(cause_sticky), .first_cause(first_cause),
      .fault_n(fault_n), .fault_event(fault_event)
   );

   // Reference model written from the requirements
   int          m_dcnt [NC];
   int          m_rcnt;
   int          m_bcnt;
   logic [NC-1:0] m_st, m_fst;
   logic          m_ev;

   function automatic logic [NC-1:0] lowest(input logic [NC-1:0] v);
      for (int k = 0; k < NC; k++) if (v[k]) return NC'(1) << k;
      return '0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NC; k++) m_dcnt[k] = 0;
         m_rcnt = 0; m_bcnt = 0; m_st = '0; m_fst = '0; m_ev = 1'b0;
      end else begin
         logic [NC-1:0] q;
         logic blanked, rhit, clr;
         int thr, rthr;
         blanked = (m_bcnt != 0);
         thr  = (deglitch_cycles == 0) ? 1 : int'(deglitch_cycles);
         rthr = (rearm_cycles == 0) ? 1 : int'(rearm_cycles);
         for (int k = 0; k < NC; k++) begin
            logic go;
            go = cause_raw[k] && arm_en && !(blanked && blank_mask[k]);
            q[k] = go && (m_dcnt[k] == thr - 1);
            if (!go) m_dcnt[k] = 0;
            else if (m_dcnt[k] < thr) m_dcnt[k]++;
         end
         rhit = rearm_in && (m_rcnt == rthr - 1);
         if (!rearm_in) m_rcnt = 0;
         else if (m_rcnt < rthr) m_rcnt++;
         clr = rhit && (cause_raw == '0);
         if (blank_start && !blanked) m_bcnt = int'(blank_cycles);
         else if (blanked) m_bcnt--;
         m_ev = !clr && (m_st == '0) && (q != '0);
         if (clr) begin
            m_st = '0; m_fst = '0;
         end else begin
            if (m_st == '0 && q != '0) m_fst = lowest(q);
            m_st = m_st | q;
         end
      end
   end

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rearm_clear();
      cause_raw = '0;
      rearm_in = 1'b1;
      tick(int'((rearm_cycles == 0) ? 1 : rearm_cycles));
      rearm_in = 1'b0;
      tick();
   endtask

   int shown = 0;
   task automatic model_cmp();
      tests++;
      if (cause_sticky !== m_st || first_cause !== m_fst ||
          fault_event !== m_ev || fault_n !== (m_st == '0)) begin
         fails++;
         if (shown < 10) begin
            shown++;
            $display("FAIL R2/R4/R6 random: actual st=%h fst=%h ev=%b fn=%b expected st=%h fst=%h ev=%b",
                     cause_sticky, first_cause, fault_event, fault_n, m_st, m_fst, m_ev);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0417));
      tick(3);
      rst_n = 1'b1;
      tick();
      // R12 reset state
      check("R12 sticky", 32'(cause_sticky), 0);
      check("R12 first", 32'(first_cause), 0);
      check("R12 fault_n", 32'(fault_n), 1);
      check("R12 event", 32'(fault_event), 0);

      // R1 short runs rejected, low sample restarts count
      cause_raw = 4'b0001; tick(2);
      cause_raw = 4'b0000; tick();
      cause_raw = 4'b0001; tick(2);
      cause_raw = 4'b0000; tick();
      check("R1 short run", 32'(cause_sticky), 0);

      // R1 exact run, R3 bit 1 overvoltage, R5, R6, R4
      cause_raw = 4'b0010; tick(2);
      check("R1 n-1 samples", 32'(cause_sticky), 0);
      tick();
      check("R3 ovp bit", 32'(cause_sticky), 32'h2);
      check("R5 fault_n low", 32'(fault_n), 0);
      check("R6 event pulse", 32'(fault_event), 1);
      check("R4 first", 32'(first_cause), 32'h2);
      tick();
      check("R6 single cycle", 32'(fault_event), 0);

      // R2 accumulate, R3 bit 3 overtemperature, R4 unchanged
      cause_raw = 4'b1000; tick(3);
      check("R2 accumulate", 32'(cause_sticky), 32'hA);
      check("R6 no pulse when latched", 32'(fault_event), 0);
      cause_raw = 4'b0000; tick(2);
      check("R2 sticky after release", 32'(cause_sticky), 32'hA);
      check("R4 first kept", 32'(first_cause), 32'h2);

      // R7 short hold ignored
      rearm_in = 1'b1; tick(3);
      rearm_in = 1'b0; tick();
      check("R7 short hold", 32'(cause_sticky), 32'hA);

      // R8 re-arm while a cause is active
      rearm_in = 1'b1; cause_raw = 4'b0100; tick(4);
      check("R8 no clear while active", 32'(cause_sticky), 32'hE);
      cause_raw = 4'b0000; tick(3);
      check("R8 one attempt per hold", 32'(cause_sticky), 32'hE);
      rearm_in = 1'b0; tick();
      rearm_in = 1'b1; tick(4);
      check("R7 clear sticky", 32'(cause_sticky), 0);
      check("R7 clear first", 32'(first_cause), 0);
      check("R7 fault_n high", 32'(fault_n), 1);
      rearm_in = 1'b0; tick();

      // R4 tie goes to lowest index
      cause_raw = 4'b0101; tick(3);
      check("R4 tie lowest", 32'(first_cause), 32'h1);
      check("R2 both set", 32'(cause_sticky), 32'h5);
      rearm_clear();

      // R9 blanking of selected cause only
      blank_cycles = 12'd10; blank_mask = 4'b0001;
      blank_start = 1'b1; tick();
      blank_start = 1'b0;
      cause_raw = 4'b0011; tick(6);
      check("R9 masked blanked, other caught", 32'(cause_sticky), 32'h2);
      cause_raw = 4'b0000; blank_start = 1'b1; tick();
      blank_start = 1'b0; tick(5);
      cause_raw = 4'b0001; tick(3);
      check("R10 window expires, retrigger ignored", 32'(cause_sticky), 32'h3);
      blank_mask = '0;
      rearm_clear();

      // R11 enable low blocks capture
      arm_en = 1'b0; cause_raw = 4'b1111; tick(5);
      check("R11 no capture", 32'(cause_sticky), 0);
      check("R11 fault_n", 32'(fault_n), 1);
      arm_en = 1'b1; tick(2);
      check("R11 counters restarted", 32'(cause_sticky), 0);
      tick();
      check("R11 capture after enable", 32'(cause_sticky), 32'hF);
      arm_en = 1'b0; cause_raw = '0; tick(2);
      check("R11 latched kept", 32'(cause_sticky), 32'hF);
      arm_en = 1'b1;
      rearm_clear();

      // R1 and R7 zero thresholds act as one
      deglitch_cycles = 8'd0; rearm_cycles = 8'd0;
      cause_raw = 4'b0100; tick();
      check("R1 zero threshold", 32'(cause_sticky), 32'h4);
      cause_raw = '0; rearm_in = 1'b1; tick();
      check("R7 zero hold", 32'(cause_sticky), 0);
      rearm_in = 1'b0; tick();

      // Random traffic against the model
      for (int c = 0; c < 6000; c++) begin
         model_cmp();
         if (c % 500 == 0) begin
            deglitch_cycles = 8'($urandom_range(1, 5));
            rearm_cycles    = 8'($urandom_range(1, 6));
            blank_cycles    = 12'($urandom_range(0, 40));
            blank_mask      = NC'($urandom);
         end
         for (int k = 0; k < NC; k++)
            if ($urandom_range(0, 7) == 0) cause_raw[k] = ~cause_raw[k];
         if ($urandom_range(0, 9) == 0) rearm_in = ~rearm_in;
         blank_start = ($urandom_range(0, 149) == 0);
         if ($urandom_range(0, 299) == 0) arm_en = ~arm_en;
         tick();
      end
      model_cmp();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule